// File: doc/BRIEF.md
# Logarithmic-Domain Multiply, Divide, Root and Square Unit

This block performs the four "hard" arithmetic operations on numbers held in logarithmic form, using only integer operations. Each 20-bit word has a sign bit in bit 19 and, in bits 18:0, the base-2 logarithm of the magnitude. The logarithm is a two's-complement fixed-point value with 8 fractional bits, so 20'h00100 means a magnitude of 2.

A product becomes a sum of logarithms and a quotient becomes their difference. A square root halves the logarithm, and squaring doubles it. Addition and subtraction of linear values are not handled here, because they need a correction table.

A caller presents an opcode and two operands with a valid strobe. One clock edge later, the registered result appears with its own valid and two exception flags. One flag reports a logarithm that had to be clamped. The other reports a square root taken of a negative-signed value. The unit accepts a new operation on every cycle.

Top module: `lns_mdu`

## Requirements
- R1: While reset is asserted, and on the first edge after it, out_valid_o, result_o, ovf_o and inv_o are all zero.
- R2: out_valid_o equals the in_valid_i value sampled on the previous rising edge. When in_valid_i is low at an edge, result_o, ovf_o and inv_o keep their values.
- R3: Opcode 2'd0 (multiply) gives a log field equal to the sum of the operand log fields (bits 18:0) and a sign (bit 19) equal to the XOR of the operand signs.
- R4: Opcode 2'd1 (divide) gives a log field equal to a's log field minus b's log field, with a sign equal to the XOR of the operand signs.
- R5: Opcode 2'd2 (root) gives a's log field shifted right by one arithmetically, which rounds toward minus infinity. The sign is 0 and b is ignored.
- R6: A root of an operand a whose sign bit is 1 sets inv_o and still returns the root of the magnitude with sign 0. Every other operation clears inv_o.
- R7: Opcode 2'd3 (square) gives a's log field shifted left by one, and the result sign is always 0.
- R8: A true log result above 18'h3FFFF (the largest positive 19-bit value) is clamped to 19'h3FFFF, and ovf_o is set.
- R9: A true log result below -2^18 is clamped to 19'h40000, and ovf_o is set.
- R10: A result that lands exactly on either limit is not flagged. ovf_o is cleared by every operation that does not clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request strobe |
| op_i | input | 2 | 0 multiply, 1 divide, 2 root of a, 3 square of a |
| a_i | input | 20 | First operand: sign in bit 19, log field in bits 18:0 |
| b_i | input | 20 | Second operand, used only by multiply and divide |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 20 | Registered result word |
| ovf_o | output | 1 | Log field was clamped at a limit |
| inv_o | output | 1 | Root requested of a negative-signed value |

## Verification
The hardest condition to reach is a log field sitting exactly on a limit. There the sum, difference or doubled value is representable but one step away from clamping, so an off-by-one in the range check would go unseen by ordinary operands. The stimulus table builds such cases on purpose. It pairs 19'h3FF00 with 19'h000FF so the sum lands on the positive limit, and it squares -2^17 to land on the negative limit. It also includes neighbouring operands that exceed each limit by one step in both directions, and it places a root of a negative value directly before an operation that must clear the flag.

// File: rtl/lns_pkg.sv
package lns_pkg;

    // Width of the two's-complement log field; the sign bit sits above it.
    localparam int unsigned LNS_LOG_W = 19;

    typedef enum logic [1:0] {
        OP_MUL    = 2'd0,
        OP_DIV    = 2'd1,
        OP_ROOT   = 2'd2,
        OP_SQUARE = 2'd3
    } lns_op_e;

endpackage

// File: rtl/lns_sat.sv
// Narrows a wider two's-complement value to OUT_W bits, clamping at the limits.
module lns_sat #(
    parameter int unsigned IN_W  = 20,
    parameter int unsigned OUT_W = 19
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o,
    output logic             clip_o
);
    localparam int unsigned TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;

    assign top_bits = val_i[IN_W-1:OUT_W-1];

    always_comb begin
        // Representable only when all bits from the new sign upward agree.
        clip_o = !((&top_bits) || !(|top_bits));
        if (!clip_o) begin
            val_o = val_i[OUT_W-1:0];
        end else if (val_i[IN_W-1]) begin
            val_o = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            val_o = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/lns_log_addsub.sv
// Sum or difference of two log fields: the multiply and divide datapath.
module lns_log_addsub #(
    parameter int unsigned W = lns_pkg::LNS_LOG_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         ovf_o
);
    logic [W:0] a_x;
    logic [W:0] b_x;
    logic [W:0] sum;

    always_comb begin
        a_x = {a_i[W-1], a_i};
        b_x = {b_i[W-1], b_i};
        // One guard bit holds every exact result of +/- on W-bit values.
        sum = sub_i ? (a_x - b_x) : (a_x + b_x);
    end

    lns_sat #(
        .IN_W (W + 1),
        .OUT_W(W)
    ) u_sat (
        .val_i (sum),
        .val_o (y_o),
        .clip_o(ovf_o)
    );

endmodule

// File: rtl/lns_log_shift.sv
// Halving (root) or doubling (square) of a log field.
module lns_log_shift #(
    parameter int unsigned W = lns_pkg::LNS_LOG_W
) (
    input  logic [W-1:0] a_i,
    input  logic         up_i,
    output logic [W-1:0] y_o,
    output logic         ovf_o
);
    logic [W:0]   dbl;
    logic [W-1:0] dbl_sat;
    logic         dbl_clip;
    logic [W-1:0] half;

    // Exact doubled value in W+1 bits.
    assign dbl  = {a_i, 1'b0};
    // Arithmetic shift right: rounds toward minus infinity.
    assign half = {a_i[W-1], a_i[W-1:1]};

    lns_sat #(
        .IN_W (W + 1),
        .OUT_W(W)
    ) u_sat (
        .val_i (dbl),
        .val_o (dbl_sat),
        .clip_o(dbl_clip)
    );

    always_comb begin
        y_o   = up_i ? dbl_sat : half;
        ovf_o = up_i & dbl_clip;
    end

endmodule

// File: rtl/lns_mdu.sv
module lns_mdu
    import lns_pkg::*;
#(
    parameter int unsigned LOG_W = lns_pkg::LNS_LOG_W
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             in_valid_i,
    input  logic [1:0]       op_i,
    input  logic [LOG_W:0]   a_i,
    input  logic [LOG_W:0]   b_i,
    output logic             out_valid_o,
    output logic [LOG_W:0]   result_o,
    output logic             ovf_o,
    output logic             inv_o
);
    localparam int unsigned WORD_W = LOG_W + 1;
    localparam logic [LOG_W-1:0] LOG_MAX = {1'b0, {(LOG_W-1){1'b1}}};
    localparam logic [LOG_W-1:0] LOG_MIN = {1'b1, {(LOG_W-1){1'b0}}};

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              inv;
    } state_t;

    state_t  state_d;
    state_t  state_q;
    lns_op_e op;

    logic [LOG_W-1:0] as_y;
    logic             as_ovf;
    logic [LOG_W-1:0] sh_y;
    logic             sh_ovf;
    logic             sign_a;
    logic             sign_b;

    assign op     = lns_op_e'(op_i);
    assign sign_a = a_i[WORD_W-1];
    assign sign_b = b_i[WORD_W-1];

    lns_log_addsub #(
        .W(LOG_W)
    ) u_addsub (
        .a_i  (a_i[LOG_W-1:0]),
        .b_i  (b_i[LOG_W-1:0]),
        .sub_i(op == OP_DIV),
        .y_o  (as_y),
        .ovf_o(as_ovf)
    );

    lns_log_shift #(
        .W(LOG_W)
    ) u_shift (
        .a_i  (a_i[LOG_W-1:0]),
        .up_i (op == OP_SQUARE),
        .y_o  (sh_y),
        .ovf_o(sh_ovf)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid_i;
        if (in_valid_i) begin
            case (op)
                OP_MUL, OP_DIV: begin
                    state_d.res = {sign_a ^ sign_b, as_y};
                    state_d.ovf = as_ovf;
                    state_d.inv = 1'b0;
                end
                OP_ROOT: begin
                    state_d.res = {1'b0, sh_y};
                    state_d.ovf = 1'b0;
                    state_d.inv = sign_a;
                end
                default: begin
                    state_d.res = {1'b0, sh_y};
                    state_d.ovf = sh_ovf;
                    state_d.inv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid_o = state_q.vld;
    assign result_o    = state_q.res;
    assign ovf_o       = state_q.ovf;
    assign inv_o       = state_q.inv;

    // R2: valid tracks the request with one cycle of latency.
    a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        in_valid_i |=> out_valid_o);

    // R2: an idle cycle leaves the result and flags untouched.
    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(ovf_o) && $stable(inv_o)));

    // R6: only a root may raise the invalid flag.
    a_r6_inv_only_root: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i != 2'd2) |=> !inv_o);

    // R5: halving a log field can never clamp.
    a_r5_root_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i == 2'd2) |=> !ovf_o);

    // R7: a square is always positive.
    a_r7_square_positive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (in_valid_i && op_i == 2'd3) |=> !result_o[WORD_W-1]);

    // R8 and R9: a clamped result sits on one of the two limits.
    a_r8_ovf_at_limit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ovf_o |-> (result_o[LOG_W-1:0] == LOG_MAX || result_o[LOG_W-1:0] == LOG_MIN));

endmodule

// File: tb/sim_lns_mdu.sv
module sim_lns_mdu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 24;

    // {op[63:62], a[61:42], b[41:22], result[21:2], ovf[1], inv[0]}
    localparam logic [63:0] VEC [NVEC] = '{
        {2'd0, 20'h00100, 20'h00200, 20'h00300, 1'b0, 1'b0},
        {2'd0, 20'h80100, 20'h00080, 20'h80180, 1'b0, 1'b0},
        {2'd0, 20'h80100, 20'h80100, 20'h00200, 1'b0, 1'b0},
        {2'd0, 20'h7FF00, 20'h00080, 20'h7FF80, 1'b0, 1'b0},
        {2'd0, 20'h3FF00, 20'h000FF, 20'h3FFFF, 1'b0, 1'b0},
        {2'd0, 20'h3FFFF, 20'h00001, 20'h3FFFF, 1'b1, 1'b0},
        {2'd0, 20'hBFFFF, 20'h00001, 20'hBFFFF, 1'b1, 1'b0},
        {2'd0, 20'h40000, 20'h7FFFF, 20'h40000, 1'b1, 1'b0},
        {2'd1, 20'h00300, 20'h00100, 20'h00200, 1'b0, 1'b0},
        {2'd1, 20'h00300, 20'h80100, 20'h80200, 1'b0, 1'b0},
        {2'd1, 20'h00100, 20'h00300, 20'h7FE00, 1'b0, 1'b0},
        {2'd1, 20'h3FFFF, 20'h7FFFF, 20'h3FFFF, 1'b1, 1'b0},
        {2'd1, 20'h40000, 20'h00001, 20'h40000, 1'b1, 1'b0},
        {2'd2, 20'h00400, 20'h00000, 20'h00200, 1'b0, 1'b0},
        {2'd2, 20'h7FFFF, 20'h12345, 20'h7FFFF, 1'b0, 1'b0},
        {2'd2, 20'h00003, 20'h00000, 20'h00001, 1'b0, 1'b0},
        {2'd2, 20'h80400, 20'h00000, 20'h00200, 1'b0, 1'b1},
        {2'd2, 20'h40000, 20'h00000, 20'h60000, 1'b0, 1'b0},
        {2'd3, 20'h00180, 20'h00000, 20'h00300, 1'b0, 1'b0},
        {2'd3, 20'h80100, 20'h00000, 20'h00200, 1'b0, 1'b0},
        {2'd3, 20'h20000, 20'h00000, 20'h3FFFF, 1'b1, 1'b0},
        {2'd3, 20'h5FFFF, 20'h00000, 20'h40000, 1'b1, 1'b0},
        {2'd3, 20'h60000, 20'h00000, 20'h40000, 1'b0, 1'b0},
        {2'd1, 20'h40000, 20'h40000, 20'h00000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [19:0] a = '0;
    logic [19:0] b = '0;
    logic        out_valid;
    logic [19:0] result;
    logic        ovf;
    logic        inv;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lns_mdu u0 (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .in_valid_i (in_valid),
        .op_i       (op),
        .a_i        (a),
        .b_i        (b),
        .out_valid_o(out_valid),
        .result_o   (result),
        .ovf_o      (ovf),
        .inv_o      (inv)
    );

    task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,ovf,inv,result} act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [63:0] v);
        if (v[1]) return v[20] ? "R9" : "R8";
        if (v[0]) return "R6";
        if (v[20:2] == 19'h3FFFF || v[20:2] == 19'h40000) return "R10";
        case (v[63:62])
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [19:0] held;
        // R1: reset state, before and after edges under reset.
        #1;
        chk("R1", {out_valid, ovf, inv, result}, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {out_valid, ovf, inv, result}, '0);
        rst_n = 1'b1;

        // Table walk, back-to-back requests.
        for (int i = 0; i < NVEC; i++) begin
            in_valid = 1'b1;
            op = VEC[i][63:62];
            a  = VEC[i][61:42];
            b  = VEC[i][41:22];
            @(negedge clk);
            chk(tag_of(VEC[i]), {out_valid, ovf, inv, result},
                {1'b1, VEC[i][1], VEC[i][0], VEC[i][21:2]});
        end

        // R6: flag after a negative root, then cleared by the next operation.
        op = 2'd2; a = 20'hFFF00; b = 20'h0;
        @(negedge clk);
        chk("R6", {out_valid, ovf, inv, result}, {1'b1, 1'b0, 1'b1, 20'h7FF80});
        op = 2'd0; a = 20'h00010; b = 20'h00020;
        @(negedge clk);
        chk("R6", {out_valid, ovf, inv, result}, {1'b1, 1'b0, 1'b0, 20'h00030});

        // R2: idle cycles hold the result even when inputs change.
        op = 2'd3; a = 20'h20000;
        @(negedge clk);
        held = result;
        chk("R2", {out_valid, ovf, inv, result}, {1'b1, 1'b1, 1'b0, 20'h3FFFF});
        in_valid = 1'b0; op = 2'd1; a = 20'h00500; b = 20'h00100;
        @(negedge clk);
        chk("R2", {out_valid, ovf, inv, result}, {1'b0, 1'b1, 1'b0, held});
        @(negedge clk);
        chk("R2", {out_valid, ovf, inv, result}, {1'b0, 1'b1, 1'b0, held});

        // R1: reset in mid-run clears everything.
        in_valid = 1'b1; op = 2'd2; a = 20'h80200;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", {out_valid, ovf, inv, result}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1", {out_valid, ovf, inv, result}, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule